// File: doc/BRIEF.md
# Quad-Lane Command/Address/Data Frame Transmitter

This block sends one write transaction over a four-wire quad-serial data bus. A one-cycle start request loads an 8-bit command, a 16-bit address and a 32-bit data word. The block then lowers an active-low select line, produces a serial clock divided down from the system clock, and drives four data lanes with one nibble per serial clock period. Each lane carries 14 bits per frame.

The command comes first, then the address with its high byte first, then the data word with its low byte first. Within every byte the most significant bit leads. A busy flag covers the whole frame, and a one-cycle done pulse marks its end. The lane output-enable follows the select line, so that a pad ring can tristate the lanes between frames. The serial clock idles low. Lanes change while the clock is low and stay stable across each rising edge.

Top module: `quad_frame_tx`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, sel_n_o=1, sclk_o=0, oe_o=0, busy_o=0, done_o=0 and lanes_o=0.
- R2: A start_i sampled high in idle drives sel_n_o low in the next cycle. The first rising edge of sclk_o comes exactly one system clock after that, and lanes_o already shows the first nibble while sel_n_o is low and sclk_o is still low.
- R3: The frame is a sequence of 7 bytes: command, address[15:8], address[7:0], data[7:0], data[15:8], data[23:16], data[31:24]. Each byte is split into two nibbles, the high nibble (bits 7:4) first. Nibble bit 3 goes on lanes_o[3] and nibble bit 0 goes on lanes_o[0].
- R4: A frame has exactly 14 rising edges of sclk_o. Each serial period lasts DIV system clocks: sclk_o is high for DIV-DIV/2 cycles and then low for DIV/2 cycles.
- R5: lanes_o changes only in the cycle in which sclk_o falls, and is stable for as long as sclk_o stays high.
- R6: After the high phase of the 14th serial clock, sel_n_o returns high in the next cycle, and done_o is high for exactly that one cycle. busy_o is high in every cycle in which sel_n_o is low.
- R7: A start_i sampled while busy_o is high is ignored. The frame in progress goes on with its original bytes and timing.
- R8: oe_o is high exactly while sel_n_o is low, and lanes_o is 0 while sel_n_o is high.
- R9: A start_i sampled in the same cycle as done_o begins a new frame at once, with the timing of R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Frame request, sampled only while idle |
| cmd_i | input | 8 | Command byte |
| addr_i | input | 16 | Address, sent high byte first |
| data_i | input | 32 | Data word, sent low byte first |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| sel_n_o | output | 1 | Active-low select |
| sclk_o | output | 1 | Serial clock, idles low |
| oe_o | output | 1 | Output enable for the four lanes |
| lanes_o | output | 4 | Quad data lanes |

## Verification
Two things can land on the same cycle. The done pulse of one frame can meet a new start request, and a start request can arrive in the middle of a frame. Both are provoked on purpose. One test raises start in exactly the cycle in which done is seen, so that the next frame follows with no idle gap. Another pulses start with different operands during the setup cycle and during shifting. A behavioural model that counts cycles from each accepted start predicts every output on every clock, and any difference shows up as a mismatch. The bench also counts serial clock rising edges per frame on its own, and uses DIV=3 so that the uneven high/low split is exercised.

// File: rtl/qft_pkg.sv
package qft_pkg;
   typedef enum logic [1:0] {
      QFT_IDLE  = 2'd0,
      QFT_SETUP = 2'd1,
      QFT_SHIFT = 2'd2
   } qft_state_e;
endpackage

// File: rtl/qft_frame_pack.sv
// Arranges command, address and data into one frame vector, first bit at the MSB.
module qft_frame_pack #(
   parameter int CMD_W  = 8,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   localparam int FRAME_W = CMD_W + ADDR_W + DATA_W
) (
   input  logic [CMD_W-1:0]   cmd_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [DATA_W-1:0]  data_i,
   output logic [FRAME_W-1:0] frame_o
);
   localparam int DBYTES = DATA_W / 8;

   if ((CMD_W % 8) != 0 || (ADDR_W % 8) != 0 || (DATA_W % 8) != 0) begin : g_chk_bytes
      $error("qft_frame_pack: all field widths must be whole bytes");
   end

   logic [DATA_W-1:0] data_le;

   // Data leaves low byte first: byte b of the word sits at frame slot b.
   for (genvar b = 0; b < DBYTES; b++) begin : g_swap
      assign data_le[DATA_W-1-8*b -: 8] = data_i[8*b +: 8];
   end

   // Address is already big-endian as a vector.
   assign frame_o = {cmd_i, addr_i, data_le};
endmodule

// File: rtl/qft_sclk_div.sv
// Serial clock generator: high phase first, then low phase, DIV cycles per period.
module qft_sclk_div #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic run_i,
   output logic sclk_o,
   output logic fall_o
);
   localparam int HI = DIV - DIV / 2;
   localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

   if (DIV < 2) begin : g_chk_div
      $error("qft_sclk_div: DIV must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || !run_i)
         cnt_q <= '0;
      else if (cnt_q == CW'(DIV - 1))
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   assign sclk_o = run_i && (cnt_q < CW'(HI));
   assign fall_o = run_i && (cnt_q == CW'(HI - 1));

   // R4: a new rising edge inside a run only follows a full period.
   assert_period_R4: assert property (@(posedge clk) disable iff (rst)
      (run_i && $past(run_i) && $rose(sclk_o)) |-> ($past(cnt_q) == CW'(DIV - 1)));
endmodule

// File: rtl/quad_frame_tx.sv
module quad_frame_tx #(
   parameter int DIV    = 4,
   parameter int LANES  = 4,
   parameter int CMD_W  = 8,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_i,
   input  logic [CMD_W-1:0]  cmd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              sel_n_o,
   output logic              sclk_o,
   output logic              oe_o,
   output logic [LANES-1:0]  lanes_o
);
   import qft_pkg::*;

   localparam int FRAME_W = CMD_W + ADDR_W + DATA_W;
   localparam int NIB     = FRAME_W / LANES;
   localparam int NIB_W   = $clog2(NIB);

   if ((FRAME_W % LANES) != 0) begin : g_chk_lanes
      $error("quad_frame_tx: frame length must divide evenly across lanes");
   end

   qft_state_e         state_q;
   logic [NIB_W-1:0]   idx_q;
   logic [FRAME_W-1:0] shreg_q;
   logic [FRAME_W-1:0] frame_w;
   logic               done_q;
   logic               fall_w;
   logic               sclk_w;

   qft_frame_pack #(.CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pack (
      .cmd_i  (cmd_i),
      .addr_i (addr_i),
      .data_i (data_i),
      .frame_o(frame_w)
   );

   qft_sclk_div #(.DIV(DIV)) u_div (
      .clk   (clk),
      .rst   (rst),
      .run_i (state_q == QFT_SHIFT),
      .sclk_o(sclk_w),
      .fall_o(fall_w)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= QFT_IDLE;
         idx_q   <= '0;
         shreg_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            QFT_IDLE: begin
               if (start_i) begin
                  shreg_q <= frame_w;
                  idx_q   <= '0;
                  state_q <= QFT_SETUP;
               end
            end
            QFT_SETUP: state_q <= QFT_SHIFT;
            QFT_SHIFT: begin
               if (fall_w) begin
                  if (idx_q == NIB_W'(NIB - 1)) begin
                     state_q <= QFT_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     idx_q   <= idx_q + 1'b1;
                     shreg_q <= shreg_q << LANES;
                  end
               end
            end
            default: state_q <= QFT_IDLE;
         endcase
      end
   end

   assign sel_n_o = (state_q == QFT_IDLE);
   assign busy_o  = !sel_n_o;
   assign oe_o    = !sel_n_o;
   assign sclk_o  = sclk_w;
   assign done_o  = done_q;
   assign lanes_o = sel_n_o ? '0 : shreg_q[FRAME_W-1 -: LANES];

   // R8: no clock activity outside the select window.
   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
      sel_n_o |-> !sclk_o);
   // R2: the first rising edge comes after at least one cycle of select low.
   assert_setup_gap_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(sclk_o) |-> ($past(!sel_n_o) && $past(!sclk_o)));
   // R5: lanes hold across the high phase.
   assert_hold_high_R5: assert property (@(posedge clk) disable iff (rst)
      (sclk_o && $past(sclk_o)) |-> $stable(lanes_o));
   // R6: done is one cycle wide and coincides with the end of select.
   assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);
   assert_done_end_R6: assert property (@(posedge clk) disable iff (rst)
      done_o |-> (sel_n_o && $past(!sel_n_o)));
   // R4: the nibble index never runs past the frame.
   assert_idx_range_R4: assert property (@(posedge clk) disable iff (rst)
      idx_q < NIB_W'(NIB));
endmodule

// File: tb/tb_quad_frame_tx.sv
module tb_quad_frame_tx;
   localparam int DIV  = 3;
   localparam int HI   = DIV - DIV / 2;
   localparam int NIB  = 14;
   localparam int LAST = 1 + (NIB - 1) * DIV + HI;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [7:0]  cmd = '0;
   logic [15:0] addr = '0;
   logic [31:0] data = '0;
   logic        busy, done, sel_n, sclk, oe;
   logic [3:0]  lanes;

   int checks = 0;
   int errors = 0;
   string tag = "R3";

   // reference model state
   int t = 0;
   int m_done = 0;
   int nib [NIB];
   int rises = 0;
   logic prev_sclk = 1'b0;
   logic prev_sel = 1'b1;

   always #5 clk = ~clk;

   quad_frame_tx #(.DIV(DIV)) dut (
      .clk(clk), .rst(rst), .start_i(start), .cmd_i(cmd), .addr_i(addr),
      .data_i(data), .busy_o(busy), .done_o(done), .sel_n_o(sel_n),
      .sclk_o(sclk), .oe_o(oe), .lanes_o(lanes)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s t=%0d actual=%0h expected=%0h", req, t, act, exp);
      end
   endtask

   task automatic load_model();
      int bytes [7];
      bytes[0] = cmd;
      bytes[1] = addr >> 8;
      bytes[2] = addr & 255;
      for (int i = 0; i < 4; i++) bytes[3 + i] = (data >> (8 * i)) & 255;
      for (int i = 0; i < 7; i++) begin
         nib[2 * i]     = bytes[i] >> 4;
         nib[2 * i + 1] = bytes[i] & 15;
      end
   endtask

   always @(posedge clk) begin
      if (rst) begin
         t = 0;
         m_done = 0;
      end else begin
         m_done = 0;
         if (t != 0) begin
            if (t == LAST) begin
               t = 0;
               m_done = 1;
            end else t = t + 1;
         end else if (start) begin
            t = 1;
            load_model();
         end
      end
   end

   always @(negedge clk) begin
      if (!rst) begin
         int e_sclk, e_idx, e_lanes;
         e_sclk  = (t >= 2 && ((t - 2) % DIV) < HI) ? 1 : 0;
         e_idx   = (t < 2) ? 0 : (t - 2) / DIV + ((((t - 2) % DIV) >= HI) ? 1 : 0);
         e_lanes = (t == 0) ? 0 : nib[e_idx];
         chk({"R6 sel ", tag}, sel_n, (t == 0) ? 1 : 0);
         chk({"R6 busy ", tag}, busy, (t != 0) ? 1 : 0);
         chk({"R6 done ", tag}, done, m_done);
         chk({"R2 R4 sclk ", tag}, sclk, e_sclk);
         chk({"R8 oe ", tag}, oe, (t != 0) ? 1 : 0);
         chk({"R3 R5 lanes ", tag}, lanes, e_lanes);
         if (sclk && !prev_sclk) rises++;
         if (sel_n && !prev_sel) begin
            chk("R4 rising edges per frame", rises, NIB);
            rises = 0;
         end
         prev_sclk = sclk;
         prev_sel  = sel_n;
      end
   end

   task automatic send(input logic [7:0] c, input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      cmd = c; addr = a; data = d; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 sel in reset", sel_n, 1);
      chk("R1 sclk in reset", sclk, 0);
      chk("R1 oe in reset", oe, 0);
      chk("R1 busy in reset", busy, 0);
      chk("R1 done in reset", done, 0);
      chk("R1 lanes in reset", lanes, 0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 sel after reset", sel_n, 1);
      chk("R1 lanes after reset", lanes, 0);

      tag = "R3 mixed";
      send(8'hA5, 16'h1234, 32'h89AB_CDEF);
      tag = "R3 ones";
      send(8'hFF, 16'hFFFF, 32'hFFFF_FFFF);
      tag = "R3 walk";
      send(8'h01, 16'h8000, 32'h0000_0080);
      tag = "R3 zeros";
      send(8'h00, 16'h0000, 32'h0100_0000);

      // R9: new start in the done cycle
      tag = "R9";
      @(negedge clk);
      cmd = 8'h3C; addr = 16'hBEEF; data = 32'h1357_9BDF; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      cmd = 8'hC3; addr = 16'h0F0F; data = 32'h2468_ACE0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R9 frame restarted", sel_n, 0);
      while (!done) @(negedge clk);

      // R7: start pulses during setup and shifting are ignored
      tag = "R7";
      @(negedge clk);
      cmd = 8'h5A; addr = 16'hA55A; data = 32'hDEAD_BEEF; start = 1'b1;
      @(negedge clk);
      cmd = 8'h11; addr = 16'h2222; data = 32'h3333_3333;
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      start = 1'b1; cmd = 8'h77;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      repeat (3) @(negedge clk);
      chk("R7 idle after ignored start", busy, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule